// File: doc/BRIEF.md
# Multi-core interrupt source router

This block sits between the interrupt sources of a four-core processor cluster and the cores' two interrupt request inputs. It takes the sources that belong to each core and the sources that the whole cluster shares, and drives one level-sensitive normal interrupt (IRQ) and one level-sensitive fast interrupt (FIQ) to each core. Each core has four timer lines and four mailbox pending flags. The shared sources are one GPU IRQ line, one GPU FIQ line and one local-timer line.

For each core, software programs one enable byte for the timer lines and one for the mailbox flags. Each enable byte chooses, per source, whether that source is masked, raises IRQ, or raises FIQ. Routing fields pick the target core for the shared sources. For each core, the block computes an IRQ source word and an FIQ source word from the current inputs and registers, with no storage in between. Software reads these words to find out why a core was interrupted. The mailbox storage and the local-timer counter are not in this block: their pending state arrives as input lines.

Top module: `irq_rtr`

## Requirements
- R1: After reset, every routing and enable register reads zero, every IRQ and FIQ output is low, and a shared source that becomes active goes to core 0 as IRQ.
- R2: In a core's source words, bits 0..3 carry that core's timer lines `tmr_irq_i[4c+n]`, bits 4..7 carry its mailbox flags `mbx_pend_i[4c+j]`, bit 8 carries the GPU and bit 11 carries the local timer. Bits 9, 10 and 12..31 always read zero.
- R3: In a core's timer or mailbox enable byte, bit n enables IRQ delivery of source n and bit n+4 enables FIQ delivery of it. With neither bit set, the source appears in neither word.
- R4: When both enable bits of a source are set, that source appears only in the FIQ word.
- R5: The GPU routing register at offset 0x0C holds the IRQ target core in bits 1:0 and the FIQ target core in bits 3:2. An active GPU IRQ line sets bit 8 of the IRQ word of its target core only, and an active GPU FIQ line sets bit 8 of the FIQ word of its target core only. The register reads back as 4 bits.
- R6: The local-timer routing register at offset 0x24 holds the target core in bits 1:0 and the kind in bit 2 (1 = FIQ, 0 = IRQ). An active local-timer line sets bit 11 in exactly one word. The register reads back as 3 bits.
- R7: The timer enable bytes sit at 0x40+4c and the mailbox enable bytes at 0x50+4c. A write keeps only the low 8 bits, and the register reads back with the upper bits zero.
- R8: The IRQ source words read at 0x60+4c and the FIQ source words at 0x70+4c, in the same cycle as the address. Writes to these offsets have no effect.
- R9: `irq_o[c]` is high exactly when core c's IRQ word is nonzero, and `fiq_o[c]` exactly when its FIQ word is nonzero. Both follow their inputs combinationally.
- R10: Inside the 0x100-byte window, reads of any other offset return zero and writes to it change no register. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 8 | Byte offset in the register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| tmr_irq_i | input | 16 | Per-core timer lines, core c at bits 4c+3..4c |
| mbx_pend_i | input | 16 | Per-core mailbox pending flags, core c at bits 4c+3..4c |
| gpu_irq_i | input | 1 | Shared GPU IRQ line |
| gpu_fiq_i | input | 1 | Shared GPU FIQ line |
| ltmr_irq_i | input | 1 | Shared local-timer interrupt line |
| irq_o | output | 4 | Per-core IRQ level |
| fiq_o | output | 4 | Per-core FIQ level |

## Verification
On every cycle, the assertions check these properties of the source words and registers:
- no local source shows in both words of a core;
- reserved bits stay zero;
- each GPU line reaches at most one core;
- the local-timer line lands in exactly one word;
- enable writes keep only their low byte;
- stray writes leave all state untouched.

The correct choice of target core, the precedence between the enable bits, and the exact read-back at each offset need the bench's reference model. The bench compares against that model after random register programming and random input patterns, and after directed cases for reset, dual enable and unmapped or read-only offsets.

// File: rtl/irq_rtr_pkg.sv
package irq_rtr_pkg;
  localparam int N_CORES  = 4;
  localparam int N_LOCAL  = 4;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int CTL_W    = 2 * N_LOCAL;
  localparam int CORE_W   = $clog2(N_CORES);
  localparam int BIT_MBX0 = N_LOCAL;
  localparam int BIT_GPU  = 8;
  localparam int BIT_LTMR = 11;

  localparam logic [ADDR_W-1:0] OFS_GPU_RT = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_LT_RT  = 8'h24;
  localparam logic [3:0] BLK_TCTL  = 4'h4;
  localparam logic [3:0] BLK_MCTL  = 4'h5;
  localparam logic [3:0] BLK_IPEND = 4'h6;
  localparam logic [3:0] BLK_FPEND = 4'h7;

  // Steering of one local source: {fiq, irq}; FIQ wins when both enables set
  function automatic logic [1:0] steer(input logic src, input logic irq_en, input logic fiq_en);
    return {src & fiq_en, src & irq_en & ~fiq_en};
  endfunction
endpackage

// File: rtl/irq_rtr_regs.sv
module irq_rtr_regs
  import irq_rtr_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             req_i,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  input  logic [N_CORES-1:0][DATA_W-1:0]   ipend_i,
  input  logic [N_CORES-1:0][DATA_W-1:0]   fpend_i,
  output logic [DATA_W-1:0]                rdata_o,
  output logic [2*CORE_W-1:0]              gpu_rt_o,
  output logic [CORE_W:0]                  lt_rt_o,
  output logic [N_CORES-1:0][CTL_W-1:0]    tctl_o,
  output logic [N_CORES-1:0][CTL_W-1:0]    mctl_o
);
  logic [ADDR_W-1:0] word_addr;
  logic [3:0]        blk;
  logic [CORE_W-1:0] idx;
  logic              wr;

  assign word_addr = {addr_i[ADDR_W-1:2], 2'b00};
  assign blk       = word_addr[7:4];
  assign idx       = word_addr[2 +: CORE_W];
  assign wr        = req_i & we_i;

  logic [2*CORE_W-1:0]           gpu_rt_q;
  logic [CORE_W:0]               lt_rt_q;
  logic [N_CORES-1:0][CTL_W-1:0] tctl_q;
  logic [N_CORES-1:0][CTL_W-1:0] mctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gpu_rt_q <= '0;
      lt_rt_q  <= '0;
      tctl_q   <= '0;
      mctl_q   <= '0;
    end else if (wr) begin
      if (word_addr == OFS_GPU_RT) gpu_rt_q <= wdata_i[2*CORE_W-1:0];
      if (word_addr == OFS_LT_RT)  lt_rt_q  <= wdata_i[CORE_W:0];
      if (blk == BLK_TCTL)         tctl_q[idx] <= wdata_i[CTL_W-1:0];
      if (blk == BLK_MCTL)         mctl_q[idx] <= wdata_i[CTL_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (word_addr == OFS_GPU_RT)     rdata_o[2*CORE_W-1:0] = gpu_rt_q;
    else if (word_addr == OFS_LT_RT) rdata_o[CORE_W:0]     = lt_rt_q;
    else begin
      case (blk)
        BLK_TCTL:  rdata_o[CTL_W-1:0] = tctl_q[idx];
        BLK_MCTL:  rdata_o[CTL_W-1:0] = mctl_q[idx];
        BLK_IPEND: rdata_o            = ipend_i[idx];
        BLK_FPEND: rdata_o            = fpend_i[idx];
        default:   rdata_o            = '0;
      endcase
    end
  end

  assign gpu_rt_o = gpu_rt_q;
  assign lt_rt_o  = lt_rt_q;
  assign tctl_o   = tctl_q;
  assign mctl_o   = mctl_q;

  logic stray_wr;
  assign stray_wr = wr && word_addr != OFS_GPU_RT && word_addr != OFS_LT_RT &&
                    blk != BLK_TCTL && blk != BLK_MCTL;

  // R7
  tctl_low_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && word_addr == 8'h40) |=> (tctl_o[0] == $past(wdata_i[CTL_W-1:0])));
  // R10
  stray_wr_no_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stray_wr |=> ($stable(gpu_rt_o) && $stable(lt_rt_o) && $stable(tctl_o) && $stable(mctl_o)));
endmodule

// File: rtl/irq_rtr_core.sv
module irq_rtr_core
  import irq_rtr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CTL_W-1:0]   tctl_i,
  input  logic [CTL_W-1:0]   mctl_i,
  input  logic [N_LOCAL-1:0] tmr_i,
  input  logic [N_LOCAL-1:0] mbx_i,
  input  logic               gpu_irq_i,
  input  logic               gpu_fiq_i,
  input  logic               lt_irq_i,
  input  logic               lt_fiq_i,
  output logic [DATA_W-1:0]  ipend_o,
  output logic [DATA_W-1:0]  fpend_o
);
  logic [N_LOCAL-1:0] t_irq, t_fiq, m_irq, m_fiq;

  for (genvar n = 0; n < N_LOCAL; n++) begin : g_src
    assign {t_fiq[n], t_irq[n]} = steer(tmr_i[n], tctl_i[n], tctl_i[n+N_LOCAL]);
    assign {m_fiq[n], m_irq[n]} = steer(mbx_i[n], mctl_i[n], mctl_i[n+N_LOCAL]);
  end

  always_comb begin
    ipend_o = '0;
    fpend_o = '0;
    ipend_o[N_LOCAL-1:0]            = t_irq;
    fpend_o[N_LOCAL-1:0]            = t_fiq;
    ipend_o[BIT_MBX0 +: N_LOCAL]    = m_irq;
    fpend_o[BIT_MBX0 +: N_LOCAL]    = m_fiq;
    ipend_o[BIT_GPU]                = gpu_irq_i;
    fpend_o[BIT_GPU]                = gpu_fiq_i;
    ipend_o[BIT_LTMR]               = lt_irq_i;
    fpend_o[BIT_LTMR]               = lt_fiq_i;
  end

  // R4
  local_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ipend_o[7:0] & fpend_o[7:0]) == 8'h00));
  // R2
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ipend_o[31:12] == '0 && fpend_o[31:12] == '0 && ipend_o[10:9] == 2'b00 && fpend_o[10:9] == 2'b00));
  // R3
  masked_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tctl_i == '0) |-> (ipend_o[3:0] == 4'h0 && fpend_o[3:0] == 4'h0));
endmodule

// File: rtl/irq_rtr.sv
module irq_rtr
  import irq_rtr_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [7:0]             addr_i,
  input  logic [31:0]            wdata_i,
  output logic [31:0]            rdata_o,
  input  logic [15:0]            tmr_irq_i,
  input  logic [15:0]            mbx_pend_i,
  input  logic                   gpu_irq_i,
  input  logic                   gpu_fiq_i,
  input  logic                   ltmr_irq_i,
  output logic [3:0]             irq_o,
  output logic [3:0]             fiq_o
);
  logic [2*CORE_W-1:0]            gpu_rt;
  logic [CORE_W:0]                lt_rt;
  logic [N_CORES-1:0][CTL_W-1:0]  tctl, mctl;
  logic [N_CORES-1:0][DATA_W-1:0] ipend, fpend;

  irq_rtr_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .ipend_i  (ipend),
    .fpend_i  (fpend),
    .rdata_o  (rdata_o),
    .gpu_rt_o (gpu_rt),
    .lt_rt_o  (lt_rt),
    .tctl_o   (tctl),
    .mctl_o   (mctl)
  );

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    logic gi, gf, li, lf;
    assign gi = gpu_irq_i  && (gpu_rt[CORE_W-1:0] == CORE_W'(c));
    assign gf = gpu_fiq_i  && (gpu_rt[2*CORE_W-1:CORE_W] == CORE_W'(c));
    assign li = ltmr_irq_i && (lt_rt[CORE_W-1:0] == CORE_W'(c)) && !lt_rt[CORE_W];
    assign lf = ltmr_irq_i && (lt_rt[CORE_W-1:0] == CORE_W'(c)) &&  lt_rt[CORE_W];

    irq_rtr_core u_core (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tctl_i    (tctl[c]),
      .mctl_i    (mctl[c]),
      .tmr_i     (tmr_irq_i[c*N_LOCAL +: N_LOCAL]),
      .mbx_i     (mbx_pend_i[c*N_LOCAL +: N_LOCAL]),
      .gpu_irq_i (gi),
      .gpu_fiq_i (gf),
      .lt_irq_i  (li),
      .lt_fiq_i  (lf),
      .ipend_o   (ipend[c]),
      .fpend_o   (fpend[c])
    );

    assign irq_o[c] = |ipend[c];
    assign fiq_o[c] = |fpend[c];
  end

  logic [N_CORES-1:0] gpu_i_bits, gpu_f_bits, lt_i_bits, lt_f_bits;
  for (genvar c = 0; c < N_CORES; c++) begin : g_obs
    assign gpu_i_bits[c] = ipend[c][BIT_GPU];
    assign gpu_f_bits[c] = fpend[c][BIT_GPU];
    assign lt_i_bits[c]  = ipend[c][BIT_LTMR];
    assign lt_f_bits[c]  = fpend[c][BIT_LTMR];
  end

  // R5
  gpu_single_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($onehot0(gpu_i_bits) && $onehot0(gpu_f_bits) && ($countones(gpu_i_bits) == int'(gpu_irq_i))));
  // R6
  ltmr_one_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($countones(lt_i_bits) + $countones(lt_f_bits)) == int'(ltmr_irq_i)));
  // R9
  out_needs_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tmr_irq_i == '0 && mbx_pend_i == '0 && !gpu_irq_i && !gpu_fiq_i && !ltmr_irq_i)
      |-> (irq_o == '0 && fiq_o == '0)));
endmodule

// File: tb/irq_rtr_tb_top.sv
module irq_rtr_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] tmr = '0, mbx = '0;
  logic        gi = 1'b0, gf = 1'b0, lt = 1'b0;
  logic [3:0]  irq, fiq;

  always #2 clk = ~clk;

  irq_rtr dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tmr_irq_i(tmr), .mbx_pend_i(mbx),
    .gpu_irq_i(gi), .gpu_fiq_i(gf), .ltmr_irq_i(lt), .irq_o(irq), .fiq_o(fiq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [3:0] sh_gpu;
  logic [2:0] sh_lt;
  logic [7:0] sh_t [4];
  logic [7:0] sh_m [4];

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req_tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int c, input bit f);
    logic [31:0] w = '0;
    for (int n = 0; n < 4; n++) begin
      logic ti, tf, mi, mf;
      tf = sh_t[c][n+4];           ti = sh_t[c][n] & ~sh_t[c][n+4];
      mf = sh_m[c][n+4];           mi = sh_m[c][n] & ~sh_m[c][n+4];
      w[n]   = tmr[4*c+n] & (f ? tf : ti);
      w[n+4] = mbx[4*c+n] & (f ? mf : mi);
    end
    if (!f && gi && sh_gpu[1:0] == c[1:0]) w[8] = 1'b1;
    if ( f && gf && sh_gpu[3:2] == c[1:0]) w[8] = 1'b1;
    if (lt && sh_lt[1:0] == c[1:0] && sh_lt[2] == f) w[11] = 1'b1;
    return w;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
    case ({a[7:2], 2'b00})
      8'h0C: sh_gpu = d[3:0];
      8'h24: sh_lt  = d[2:0];
      default: begin
        if (a[7:4] == 4'h4) sh_t[a[3:2]] = d[7:0];
        if (a[7:4] == 4'h5) sh_m[a[3:2]] = d[7:0];
      end
    endcase
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
    req = 0;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    logic [3:0] ei, ef;
    for (int c = 0; c < 4; c++) begin
      rd(8'h60 + 8'(4*c), d); chk({tag, " R2 R3 R4 R8 irq word"}, d, exp_word(c, 0));
      rd(8'h70 + 8'(4*c), d); chk({tag, " R2 R3 R4 R8 fiq word"}, d, exp_word(c, 1));
      ei[c] = |exp_word(c, 0);
      ef[c] = |exp_word(c, 1);
    end
    chk({tag, " R9 irq_o"}, {28'd0, irq}, {28'd0, ei});
    chk({tag, " R9 fiq_o"}, {28'd0, fiq}, {28'd0, ef});
  endtask

  task automatic check_regs(input string tag);
    logic [31:0] d;
    rd(8'h0C, d); chk({tag, " R5 gpu route"}, d, {28'd0, sh_gpu});
    rd(8'h24, d); chk({tag, " R6 ltmr route"}, d, {29'd0, sh_lt});
    for (int c = 0; c < 4; c++) begin
      rd(8'h40 + 8'(4*c), d); chk({tag, " R7 tctl"}, d, {24'd0, sh_t[c]});
      rd(8'h50 + 8'(4*c), d); chk({tag, " R7 mctl"}, d, {24'd0, sh_m[c]});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1234_5678));
    sh_gpu = '0; sh_lt = '0;
    for (int c = 0; c < 4; c++) begin sh_t[c] = '0; sh_m[c] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1: reset state and default routing of shared sources
    check_regs("R1 reset");
    chk("R1 outputs low", {24'd0, irq, fiq}, 32'd0);
    @(negedge clk); gi = 1; gf = 1; lt = 1;
    #1 chk("R1 shared default irq_o", {28'd0, irq}, 32'd1);
    chk("R1 shared default fiq_o", {28'd0, fiq}, 32'd1);
    check_all("R1");

    // R4: both enables -> FIQ only
    gi = 0; gf = 0; lt = 0;
    wr(8'h40, 32'hFFFF_FFFF); wr(8'h54, 32'h0000_00F3);
    tmr = 16'h000F; mbx = 16'h00F0;
    check_all("R4 dual");
    rd(8'h60, d); chk("R4 core0 irq word empty", d, 32'd0);
    rd(8'h70, d); chk("R4 core0 fiq word", d, 32'h0000_000F);
    check_regs("R7 low byte");

    // R10/R8: writes to read-only and unmapped offsets
    wr(8'h60, 32'hFFFF_FFFF); wr(8'h74, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h80, 32'hFFFF_FFFF); wr(8'hFC, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h28, 32'hFFFF_FFFF);
    check_regs("R10 stray write");
    check_all("R8 ro write");
    rd(8'h30, d); chk("R10 unmapped read", d, 32'd0);
    rd(8'hC4, d); chk("R10 unmapped read high", d, 32'd0);
    rd(8'h0F, d); chk("R10 low addr bits ignored", d, {28'd0, sh_gpu});

    // R5/R6 directed routing
    wr(8'h0C, 32'h0000_000E); wr(8'h24, 32'h0000_0007);
    gi = 1; gf = 1; lt = 1; tmr = '0; mbx = '0;
    check_all("R5 R6 directed");
    rd(8'h68, d); chk("R5 gpu irq to core2", d, 32'h0000_0100);
    rd(8'h7C, d); chk("R5 R6 gpu fiq and ltmr to core3", d, 32'h0000_0900);

    // Random programming and inputs
    for (int it = 0; it < 120; it++) begin
      int k;
      k = $urandom_range(0, 5);
      for (int j = 0; j < k; j++) begin
        logic [7:0] a;
        a = 8'($urandom_range(0, 63) * 4);
        if (($urandom & 1) == 1) a = {4'h4 + 4'($urandom_range(0, 1)), a[3:0]};
        if (a[7:4] == 4'h6 || a[7:4] == 4'h7 || a == 8'h0C || a == 8'h24 || a[7:4] == 4'h4 || a[7:4] == 4'h5 || 1)
          wr(a, $urandom);
      end
      @(negedge clk);
      tmr = 16'($urandom); mbx = 16'($urandom);
      gi = 1'($urandom); gf = 1'($urandom); lt = 1'($urandom);
      check_all("rand");
      if (it % 20 == 0) check_regs("rand");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule